// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes on an asynchronous serial line. Software-style logic writes a byte into a one-entry holding register. A separate shift register drives the line. Each frame is one low start bit, then eight data bits (or nine in wide mode) sent least significant bit first, then one high stop bit. Because there are two registers, one byte can wait in the holding register while the previous frame is still shifting out, so frames can follow each other with no idle gap.

Bit timing comes from an 8-bit divisor counter. The counter emits a sub-tick once every divisor+1 clocks. A second counter groups the sub-ticks into bit periods of 16 or 64 sub-ticks, chosen by a high-speed select input. A buffer-empty flag, gated by an interrupt enable, tells the host when the next byte can be written. A separate status bit shows when the shift register has drained. Dropping the enable aborts the frame in progress and turns off the line driver.

Top module: `serial_tx_dbuf`

## Requirements
- R1: An 8-bit frame on `ser_out` is a start bit (0), then `wr_byte` bit 0 through bit 7, then a stop bit (1).
- R2: When `nine_bit_mode` is 1 at the moment of transfer, the frame carries a ninth data bit between data bit 7 and the stop bit.
- R3: Every bit lasts (`baud_div`+1)×16 clocks when `hs_select` is 1, and (`baud_div`+1)×64 clocks when `hs_select` is 0.
- R4: When the shift register is empty and `tx_enable` is 1, a written byte moves to the shift register on the clock after the write. As a result, `buf_empty` is 0 for exactly one cycle and `shift_empty` drops on that same clock.
- R5: A byte written while a frame is shifting stays in the holding register until that frame's stop bit ends. Its start bit then follows the stop bit with no idle clocks.
- R6: `buf_empty` is 1 whenever the holding register is empty, whatever the value of `irq_enable`. Only a write makes it 0, and it stays 0 until the byte is transferred.
- R7: `irq` is 1 exactly when `buf_empty` and `irq_enable` are both 1.
- R8: `shift_empty` is 1 while no frame is loaded or shifting, and 0 from the transfer until the stop bit ends.
- R9: Dropping `tx_enable` in the middle of a frame aborts it. `ser_oe` goes to 0, and `shift_empty` is 1 on the next clock.
- R10: A byte written while `tx_enable` is 0 stays in the holding register (`buf_empty` = 0, `shift_empty` = 1). It is sent after `tx_enable` rises and a bit tick occurs.
- R11: The ninth bit is the value of `ninth_val` at the transfer clock. Later changes to `ninth_val` do not alter the frame in progress.
- R12: While enabled with no frame loaded, `ser_out` holds 1 (mark).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_enable | input | 1 | Transmitter enable; 0 aborts and tri-states the line |
| baud_div | input | 8 | Divisor; sub-tick period is baud_div+1 clocks |
| hs_select | input | 1 | 1: 16 sub-ticks per bit, 0: 64 sub-ticks per bit |
| nine_bit_mode | input | 1 | 1 selects nine data bits |
| ninth_val | input | 1 | Value of the ninth data bit |
| wr_strobe | input | 1 | One-cycle write into the holding register |
| wr_byte | input | 8 | Byte to write |
| irq_enable | input | 1 | Gates buf_empty onto irq |
| buf_empty | output | 1 | Holding register empty flag |
| irq | output | 1 | Interrupt request |
| shift_empty | output | 1 | Shift register empty status |
| ser_out | output | 1 | Serial data line |
| ser_oe | output | 1 | Output enable of the serial line driver |

## Verification
The bench queues a second byte immediately behind the first and measures the clocks between the first frame's stop sample and the next start edge. A design that transferred early would corrupt the first frame, and one that paused would show a gap. In nine-bit mode, the ninth-bit input is flipped right after the transfer. A design that read the input live instead of latching it would send the wrong ninth bit. The flag is watched clock by clock around a write: a slow transfer would hold it low for more than one cycle, and a clear on disable would lose the byte written before enabling. An abort in the middle of a frame must release the line and empty the shifter on the next clock; a design that finished the frame would keep driving the line.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_WAIT = 2'd1,
    SH_SEND = 2'd2
  } sh_state_e;

  // Sub-ticks per bit for the chosen speed.
  function automatic int unsigned osr_ratio(logic hs, int unsigned hi, int unsigned lo);
    return hs ? hi : lo;
  endfunction

  // Clocks per bit for a divisor and speed.
  function automatic int unsigned bit_clocks(int unsigned div, logic hs,
                                             int unsigned hi, int unsigned lo);
    return (div + 1) * osr_ratio(hs, hi, lo);
  endfunction

  // Bits on the line for one frame: start, data, optional ninth, stop.
  function automatic int unsigned frame_bits(logic nine, int unsigned data_w);
    return data_w + (nine ? 3 : 2);
  endfunction

endpackage

// File: rtl/stx_baud_gen.sv
module stx_baud_gen #(
  parameter int DIV_W  = 8,
  parameter int OSR_HI = 16,
  parameter int OSR_LO = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hs_select,
  input  logic [DIV_W-1:0] divisor,
  output logic             bit_tick
);
  import stx_pkg::*;

  localparam int OSR_W = $clog2(OSR_LO);

  logic [DIV_W-1:0] pre_q;
  logic [OSR_W-1:0] os_q;
  logic [OSR_W-1:0] os_last;
  logic             sub_tick;

  always_comb begin
    os_last  = OSR_W'(osr_ratio(hs_select, OSR_HI, OSR_LO) - 1);
    sub_tick = run && (pre_q == '0);
    bit_tick = sub_tick && (os_q == os_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      os_q  <= '0;
    end else if (!run) begin
      pre_q <= divisor;
      os_q  <= '0;
    end else begin
      pre_q <= sub_tick ? divisor : pre_q - 1'b1;
      if (sub_tick) os_q <= bit_tick ? '0 : os_q + 1'b1;
    end
  end

  assert_osr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> (os_q == '0));

  assert_osr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_tick && !bit_tick) |=> (os_q == $past(os_q) + 1'b1));

endmodule

// File: rtl/stx_hold_reg.sv
module stx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              xfer,
  output logic              hold_valid,
  output logic [DATA_W-1:0] hold_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else if (wr_strobe) begin
      hold_valid <= 1'b1;
      hold_data  <= wr_byte;
    end else if (xfer) begin
      hold_valid <= 1'b0;
    end
  end

  assert_write_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> hold_valid);

  assert_only_write_clears_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_valid && !wr_strobe) |=> !hold_valid);

  assert_held_until_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && !xfer) |=> hold_valid);

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_tick,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              nine_bit_mode,
  input  logic              ninth_val,
  output logic              xfer,
  output logic              shift_empty,
  output logic              line
);
  import stx_pkg::*;

  localparam int FRAME_W = DATA_W + 3;
  localparam int LEFT_W  = $clog2(FRAME_W + 1);

  sh_state_e           st_q;
  logic [FRAME_W-1:0]  frame_q;
  logic [LEFT_W-1:0]   left_q;
  logic                last_bit_done;

  function automatic logic [FRAME_W-1:0] build_frame(logic [DATA_W-1:0] d, logic nine,
                                                     logic b9);
    return {1'b1, (nine ? b9 : 1'b1), d, 1'b0};
  endfunction

  always_comb begin
    last_bit_done = (st_q == SH_SEND) && bit_tick && (left_q == LEFT_W'(1));
    xfer          = en && hold_valid && ((st_q == SH_IDLE) || last_bit_done);
    shift_empty   = (st_q == SH_IDLE);
    line          = (st_q == SH_SEND) ? frame_q[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SH_IDLE;
      frame_q <= '1;
      left_q  <= '0;
    end else if (!en) begin
      st_q    <= SH_IDLE;
      frame_q <= '1;
      left_q  <= '0;
    end else if (xfer) begin
      frame_q <= build_frame(hold_data, nine_bit_mode, ninth_val);
      left_q  <= LEFT_W'(frame_bits(nine_bit_mode, DATA_W));
      st_q    <= (st_q == SH_IDLE) ? SH_WAIT : SH_SEND;
    end else begin
      unique case (st_q)
        SH_WAIT: if (bit_tick) st_q <= SH_SEND;
        SH_SEND: if (bit_tick) begin
          frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
          left_q  <= left_q - 1'b1;
          if (left_q == LEFT_W'(1)) st_q <= SH_IDLE;
        end
        default: ;
      endcase
    end
  end

  assert_xfer_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !shift_empty);

  assert_disable_resets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> shift_empty);

  assert_chain_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit_done && xfer) |=> (st_q == SH_SEND && !line));

endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int OSR_HI = 16,
  parameter int OSR_LO = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              hs_select,
  input  logic              nine_bit_mode,
  input  logic              ninth_val,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              irq_enable,
  output logic              buf_empty,
  output logic              irq,
  output logic              shift_empty,
  output logic              ser_out,
  output logic              ser_oe
);

  logic              bit_tick;
  logic              xfer;
  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              line;

  stx_baud_gen #(.DIV_W(DIV_W), .OSR_HI(OSR_HI), .OSR_LO(OSR_LO)) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (tx_enable),
    .hs_select (hs_select),
    .divisor   (baud_div),
    .bit_tick  (bit_tick)
  );

  stx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_strobe  (wr_strobe),
    .wr_byte    (wr_byte),
    .xfer       (xfer),
    .hold_valid (hold_valid),
    .hold_data  (hold_data)
  );

  stx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (tx_enable),
    .bit_tick      (bit_tick),
    .hold_valid    (hold_valid),
    .hold_data     (hold_data),
    .nine_bit_mode (nine_bit_mode),
    .ninth_val     (ninth_val),
    .xfer          (xfer),
    .shift_empty   (shift_empty),
    .line          (line)
  );

  always_comb begin
    buf_empty = !hold_valid;
    irq       = buf_empty && irq_enable;
    ser_oe    = tx_enable;
    ser_out   = line;
  end

  assert_abort_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_oe |=> shift_empty);

  assert_idle_mark_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && shift_empty) |-> ser_out);

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !hold_valid);

endmodule

// File: tb/serial_tx_dbuf_bench.sv
`timescale 1ns/1ps
module serial_tx_dbuf_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_enable = 1'b0;
  logic [7:0] baud_div = 8'd2;
  logic       hs_select = 1'b1;
  logic       nine_bit_mode = 1'b0;
  logic       ninth_val = 1'b0;
  logic       wr_strobe = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       irq_enable = 1'b0;
  logic       buf_empty, irq, shift_empty, ser_out, ser_oe;

  always #5 clk = ~clk;

  serial_tx_dbuf u_serial_tx_dbuf (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .baud_div(baud_div),
    .hs_select(hs_select), .nine_bit_mode(nine_bit_mode), .ninth_val(ninth_val),
    .wr_strobe(wr_strobe), .wr_byte(wr_byte), .irq_enable(irq_enable),
    .buf_empty(buf_empty), .irq(irq), .shift_empty(shift_empty),
    .ser_out(ser_out), .ser_oe(ser_oe)
  );

  typedef struct {
    logic [7:0] d;
    bit         nine;
    bit         b9;
    bit         abort_f;
    bit         b2b;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  int   cur_p = 48;
  bit   mon_busy = 1'b0;

  task automatic check(bit ok, string tag, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic wait_neg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Bit period from the requirement R3: (div+1) times 16 or 64.
  function automatic int period(int div, bit hs);
    return (div + 1) * (hs ? 16 : 64);
  endfunction

  task automatic write_byte(logic [7:0] b, bit nine, bit b9, bit ab, bit chained, string tag);
    exp_t it;
    it.d = b; it.nine = nine; it.b9 = b9; it.abort_f = ab; it.b2b = chained; it.tag = tag;
    exp_q.push_back(it);
    wr_byte   = b;
    wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
  endtask

  task automatic wait_idle();
    wait_neg(3);
    while (!shift_empty) @(negedge clk);
  endtask

  // Monitor: pops the expected item at each start edge and decodes mid-bit.
  initial begin
    bit prev, chk_gap;
    int gap;
    prev = 1'b1; chk_gap = 1'b0; gap = 0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (!ser_oe) begin prev = 1'b1; chk_gap = 1'b0; continue; end
      if (prev && !ser_out) begin
        exp_t it;
        logic [7:0] d;
        logic st, sp, b9;
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected frame", 1, 0);
          prev = 1'b0;
          continue;
        end
        it = exp_q.pop_front();
        mon_busy = 1'b1;
        if (it.b2b)
          check(chk_gap && gap == cur_p/2 - 1, {it.tag, " R5 back-to-back gap"}, gap, cur_p/2 - 1);
        if (it.abort_f) begin
          while (ser_oe) @(negedge clk);
          prev = 1'b1; chk_gap = 1'b0; mon_busy = 1'b0;
          continue;
        end
        wait_neg(cur_p/2);
        st = ser_out;
        for (int i = 0; i < 8; i++) begin wait_neg(cur_p); d[i] = ser_out; end
        b9 = 1'b0;
        if (it.nine) begin wait_neg(cur_p); b9 = ser_out; end
        wait_neg(cur_p);
        sp = ser_out;
        check(st == 1'b0, {it.tag, " R1 start bit"}, st, 0);
        check(d == it.d, {it.tag, " R1 data bits"}, d, it.d);
        if (it.nine) check(b9 == it.b9, {it.tag, " R2 ninth bit"}, b9, it.b9);
        check(sp == 1'b1, {it.tag, " R1 stop bit"}, sp, 1);
        prev = 1'b1; chk_gap = 1'b1; gap = 0; mon_busy = 1'b0;
        continue;
      end
      prev = ser_out;
      gap++;
    end
  end

  // Watchdog
  initial begin
    #(150000 * 10);
    n_checks++; n_fail++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cnt;
    wait_neg(3);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check(buf_empty == 1'b1, "R6 reset buf_empty", buf_empty, 1);
    check(shift_empty == 1'b1, "R8 reset shift_empty", shift_empty, 1);
    check(ser_oe == 1'b0, "R9 reset ser_oe", ser_oe, 0);
    check(irq == 1'b0, "R7 irq gated off", irq, 0);

    // Enable at P = 48
    baud_div = 8'd2; hs_select = 1'b1; cur_p = period(2, 1'b1);
    tx_enable = 1'b1;
    wait_neg(5);
    check(ser_oe && ser_out, "R12 idle mark", {ser_oe, ser_out}, 3);
    check(buf_empty == 1'b1 && irq == 1'b0, "R6 R7 flag set irq off", {buf_empty, irq}, 2);
    irq_enable = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R7 irq follows flag", irq, 1);

    // Single write: transfer timing, then queue a second byte
    write_byte(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, "f1");
    check(buf_empty == 1'b0 && irq == 1'b0, "R4 R7 flag low after write", {buf_empty, irq}, 0);
    @(negedge clk);
    check(buf_empty == 1'b1, "R4 transfer next clock", buf_empty, 1);
    check(shift_empty == 1'b0, "R8 shift loaded", shift_empty, 0);
    write_byte(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, "f2");
    check(buf_empty == 1'b0, "R6 queued byte clears flag", buf_empty, 0);
    wait_neg(5 * cur_p);
    check(buf_empty == 1'b0, "R5 R6 held during frame", buf_empty, 0);
    while (!buf_empty) @(negedge clk);
    check(shift_empty == 1'b0, "R5 chained load at stop end", shift_empty, 0);
    wait_idle();
    check(shift_empty == 1'b1 && ser_out == 1'b1, "R8 R12 drained", {shift_empty, ser_out}, 3);

    // R3 bit width at 16x
    write_byte(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "f3");
    while (ser_out) @(negedge clk);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!ser_out);
    check(cnt == 9 * cur_p, "R3 low run at 16x", cnt, 9 * cur_p);
    wait_idle();
    while (mon_busy) @(negedge clk);

    // R3 bit width at 64x
    baud_div = 8'd0; hs_select = 1'b0; cur_p = period(0, 1'b0);
    wait_neg(2);
    write_byte(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "f4");
    while (ser_out) @(negedge clk);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!ser_out);
    check(cnt == 9 * cur_p, "R3 low run at 64x", cnt, 9 * cur_p);
    wait_idle();
    while (mon_busy) @(negedge clk);

    // Nine-bit mode, late change of ninth value, chained second frame
    baud_div = 8'd1; hs_select = 1'b1; cur_p = period(1, 1'b1);
    nine_bit_mode = 1'b1; ninth_val = 1'b1;
    wait_neg(2);
    write_byte(8'h81, 1'b1, 1'b1, 1'b0, 1'b0, "f5 R11");
    @(negedge clk);
    ninth_val = 1'b0;
    write_byte(8'h7E, 1'b1, 1'b0, 1'b0, 1'b1, "f6 R2");
    wait_idle();
    while (mon_busy) @(negedge clk);

    // Abort in mid-frame
    nine_bit_mode = 1'b0;
    write_byte(8'hC3, 1'b0, 1'b0, 1'b1, 1'b0, "f7 abort");
    wait_neg(3 * cur_p);
    check(shift_empty == 1'b0, "R8 busy before abort", shift_empty, 0);
    tx_enable = 1'b0;
    @(negedge clk);
    check(ser_oe == 1'b0, "R9 line released", ser_oe, 0);
    check(shift_empty == 1'b1, "R9 shifter reset", shift_empty, 1);
    while (mon_busy) @(negedge clk);

    // Write before enable
    write_byte(8'h96, 1'b0, 1'b0, 1'b0, 1'b0, "f8 R10");
    wait_neg(4);
    check(buf_empty == 1'b0 && shift_empty == 1'b1, "R10 byte held while disabled",
          {buf_empty, shift_empty}, 1);
    tx_enable = 1'b1;
    wait_idle();
    while (mon_busy) @(negedge clk);
    check(exp_q.size() == 0, "R1 all frames seen", exp_q.size(), 0);
    finish_run();
  end

endmodule